// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small processor core and performs the context switch for interrupts. The core reports each instruction boundary and the address of the next instruction. When an interrupt request is pending, the global enable is set and an instruction has just finished, the sequencer starts an entry sequence. It pushes the next address onto a hardware return stack, copies the working, status and bank-select registers into shadow copies and clears the global enable. It then hands the core a vector address chosen by the request's priority.

The core reports two kinds of return. A plain return takes the top address off the stack and hands it back as the new program counter. A return-from-interrupt does the same, also drives the shadow copies back to the core with a restore pulse, and sets the global enable again. The stack is a fixed number of entries deep. A push onto a full stack or a pop from an empty one raises a flag, and the flag stays set until reset.

Top module: `irq_ctx_seq`

## Requirements
- R1: An entry sequence starts only at a clock edge where `insn_done`, `irq_req` and `gie` are all high. A pending request without an instruction boundary never starts one.
- R2: On entry, `pc_next` is pushed onto the return stack. Later returns hand the stored addresses back in last-in, first-out order.
- R3: `entry_busy` is high for exactly two cycles after the entry edge. In the second of those cycles, `pc_load` is high and `pc_target` is 0x0008 when `irq_hi` was 1 (high priority) or 0x0018 when it was 0 (low priority).
- R4: `gie` reads 0 from the cycle after the entry edge. While `gie` is 0, requests are ignored.
- R5: The values on `w_in`, `status_in` and `bsr_in` at the entry edge are kept as shadow copies and driven on `w_out`, `status_out` and `bsr_out`.
- R6: One cycle after a `ret_irq` strobe, `pc_load` is high with the popped address on `pc_target`, `reg_restore` is high for that one cycle, and `gie` reads 1.
- R7: One cycle after a `ret_plain` strobe, `pc_load` is high with the popped address. `reg_restore` stays low and `gie` keeps its value.
- R8: A push while the stack already holds DEPTH entries (default 31) stores nothing and sets `stk_ovf`, which stays high until reset.
- R9: A pop from an empty stack sets `stk_unf`, which stays high until reset. The address handed back is 0x0000.
- R10: After reset, `pc_target` is 0x0000, `pc_load`, `entry_busy`, `reg_restore`, `gie`, `stk_ovf` and `stk_unf` are 0, and the stack is empty.
- R11: A return strobe at the same edge as a qualified request wins, and no entry starts. When both return strobes are high, the return-from-interrupt is performed.
- R12: A `gie_set` strobe while idle makes `gie` read 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction has completed this cycle |
| irq_req | input | 1 | Interrupt request pending |
| irq_hi | input | 1 | Priority tag of the request: 1 high, 0 low |
| ret_plain | input | 1 | Subroutine return strobe |
| ret_irq | input | 1 | Return-from-interrupt strobe |
| gie_set | input | 1 | Set the global interrupt enable |
| pc_next | input | PCW | Address of the next instruction |
| w_in | input | RW | Working register value |
| status_in | input | RW | Status register value |
| bsr_in | input | RW | Bank-select register value |
| entry_busy | output | 1 | Entry sequence in progress; core holds |
| pc_load | output | 1 | Load `pc_target` into the program counter |
| pc_target | output | PCW | New program counter value |
| reg_restore | output | 1 | Load the shadow values into the core registers |
| w_out | output | RW | Shadow working register |
| status_out | output | RW | Shadow status register |
| bsr_out | output | RW | Shadow bank-select register |
| gie | output | 1 | Global interrupt enable |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| stk_unf | output | 1 | Sticky stack underflow flag |

## Verification
All results are registered once. The stack pointer, the enable, the shadow copies and the overflow and underflow flags change at the entry or return edge and are read one cycle later. The vector appears two edges after the entry edge. A popped address and the restore pulse appear one edge after the return strobe. The bench drives each stimulus on a falling edge and then samples at the falling edge that follows each rising edge, so each result is read in exactly the cycle it is due. A small stack is swept through every fill level up to overflow and back past underflow.

// File: rtl/irq_ctx_pkg.sv
`timescale 1ns/1ps
package irq_ctx_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SAVE = 2'd1,
        SQ_VECT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/irq_ret_stack.sv
`timescale 1ns/1ps
module irq_ret_stack #(
    parameter int PCW   = 16,
    parameter int DEPTH = 31
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [PCW-1:0] wdata,
    output logic [PCW-1:0] top,
    output logic           ovf,
    output logic           unf,
    output logic           empty
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [SPW-1:0] sp;
        logic           ovf;
        logic           unf;
    } stk_t;

    stk_t           stk_d, stk_q;
    logic           full;
    logic           wr_en;
    logic [SPW-1:0] sp_m1;
    logic [PCW-1:0] mem [DEPTH];

    assign full  = (stk_q.sp == SPW'(DEPTH));
    assign empty = (stk_q.sp == '0);
    assign sp_m1 = stk_q.sp - SPW'(1);

    always_comb begin
        stk_d = stk_q;
        wr_en = 1'b0;
        if (push) begin
            if (full) begin
                stk_d.ovf = 1'b1;
            end else begin
                stk_d.sp = stk_q.sp + SPW'(1);
                wr_en    = 1'b1;
            end
        end else if (pop) begin
            if (empty) begin
                stk_d.unf = 1'b1;
            end else begin
                stk_d.sp = sp_m1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[stk_q.sp[IXW-1:0]] <= wdata;
        end
    end

    assign top = empty ? '0 : mem[sp_m1[IXW-1:0]];
    assign ovf = stk_q.ovf;
    assign unf = stk_q.unf;
endmodule

// File: rtl/irq_shadow.sv
`timescale 1ns/1ps
module irq_shadow #(
    parameter int RW   = 8,
    parameter int NREG = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap,
    input  logic [NREG-1:0][RW-1:0]  din,
    output logic [NREG-1:0][RW-1:0]  dout
);
    for (genvar g = 0; g < NREG; g++) begin : g_fld
        logic [RW-1:0] fld_d, fld_q;

        always_comb begin
            fld_d = cap ? din[g] : fld_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q <= '0;
            end else begin
                fld_q <= fld_d;
            end
        end

        assign dout[g] = fld_q;
    end
endmodule

// File: rtl/irq_ctx_seq.sv
`timescale 1ns/1ps
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int PCW     = 16,
    parameter int RW      = 8,
    parameter int DEPTH   = 31,
    parameter int VEC_HI  = 8,
    parameter int VEC_LO  = 24,
    parameter int VEC_RST = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           insn_done,
    input  logic           irq_req,
    input  logic           irq_hi,
    input  logic           ret_plain,
    input  logic           ret_irq,
    input  logic           gie_set,
    input  logic [PCW-1:0] pc_next,
    input  logic [RW-1:0]  w_in,
    input  logic [RW-1:0]  status_in,
    input  logic [RW-1:0]  bsr_in,
    output logic           entry_busy,
    output logic           pc_load,
    output logic [PCW-1:0] pc_target,
    output logic           reg_restore,
    output logic [RW-1:0]  w_out,
    output logic [RW-1:0]  status_out,
    output logic [RW-1:0]  bsr_out,
    output logic           gie,
    output logic           stk_ovf,
    output logic           stk_unf
);
    localparam int NREG = 3;

    typedef struct packed {
        seq_st_e        st;
        logic           hi;
        logic           gie;
        logic           pc_load;
        logic [PCW-1:0] pc_tgt;
        logic           restore;
    } seq_t;

    seq_t                     seq_d, seq_q;
    logic                     push, pop, shadow_cap;
    logic                     stk_empty;
    logic [PCW-1:0]           stk_top;
    logic [NREG-1:0][RW-1:0]  sh_in, sh_out;

    always_comb begin
        seq_d         = seq_q;
        seq_d.pc_load = 1'b0;
        seq_d.restore = 1'b0;
        push          = 1'b0;
        pop           = 1'b0;
        shadow_cap    = 1'b0;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (gie_set) begin
                    seq_d.gie = 1'b1;
                end
                if (ret_irq) begin
                    pop           = 1'b1;
                    seq_d.pc_load = 1'b1;
                    seq_d.pc_tgt  = stk_top;
                    seq_d.restore = 1'b1;
                    seq_d.gie     = 1'b1;
                end else if (ret_plain) begin
                    pop           = 1'b1;
                    seq_d.pc_load = 1'b1;
                    seq_d.pc_tgt  = stk_top;
                end else if (insn_done && irq_req && seq_q.gie) begin
                    push       = 1'b1;
                    shadow_cap = 1'b1;
                    seq_d.gie  = 1'b0;
                    seq_d.hi   = irq_hi;
                    seq_d.st   = SQ_SAVE;
                end
            end
            SQ_SAVE: begin
                seq_d.st      = SQ_VECT;
                seq_d.pc_load = 1'b1;
                seq_d.pc_tgt  = seq_q.hi ? PCW'(VEC_HI) : PCW'(VEC_LO);
            end
            SQ_VECT: begin
                seq_d.st = SQ_IDLE;
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st      <= SQ_IDLE;
            seq_q.hi      <= 1'b0;
            seq_q.gie     <= 1'b0;
            seq_q.pc_load <= 1'b0;
            seq_q.pc_tgt  <= PCW'(VEC_RST);
            seq_q.restore <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    irq_ret_stack #(
        .PCW   (PCW),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (pc_next),
        .top   (stk_top),
        .ovf   (stk_ovf),
        .unf   (stk_unf),
        .empty (stk_empty)
    );

    assign sh_in[0] = w_in;
    assign sh_in[1] = status_in;
    assign sh_in[2] = bsr_in;

    irq_shadow #(
        .RW   (RW),
        .NREG (NREG)
    ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (shadow_cap),
        .din   (sh_in),
        .dout  (sh_out)
    );

    assign w_out       = sh_out[0];
    assign status_out  = sh_out[1];
    assign bsr_out     = sh_out[2];
    assign entry_busy  = (seq_q.st != SQ_IDLE);
    assign pc_load     = seq_q.pc_load;
    assign pc_target   = seq_q.pc_tgt;
    assign reg_restore = seq_q.restore;
    assign gie         = seq_q.gie;

    logic unused_ok;
    assign unused_ok = stk_empty;
endmodule

// File: rtl/irq_ctx_chk.sv
`timescale 1ns/1ps
module irq_ctx_chk #(
    parameter int PCW    = 16,
    parameter int VEC_HI = 8,
    parameter int VEC_LO = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           insn_done,
    input logic           irq_req,
    input logic           ret_plain,
    input logic           ret_irq,
    input logic           gie_set,
    input logic           entry_busy,
    input logic           pc_load,
    input logic [PCW-1:0] pc_target,
    input logic           reg_restore,
    input logic           gie,
    input logic           stk_ovf,
    input logic           stk_unf
);
    a_r1_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy) |-> $past(insn_done && irq_req && gie));

    a_r3_vector_in_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_busy && $past(entry_busy)) |->
            (pc_load && (pc_target == PCW'(VEC_HI) || pc_target == PCW'(VEC_LO))));

    a_r3_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_busy && $past(entry_busy)) |=> !entry_busy);

    a_r4_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy) |-> !gie);

    a_r6_reti_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_irq && !entry_busy) |=> (pc_load && reg_restore && gie));

    a_r7_plain_keeps_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_plain && !ret_irq && !entry_busy && !gie_set) |=>
            (pc_load && !reg_restore && gie == $past(gie)));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> stk_ovf);

    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf |=> stk_unf);
endmodule

bind irq_ctx_seq irq_ctx_chk #(
    .PCW    (PCW),
    .VEC_HI (VEC_HI),
    .VEC_LO (VEC_LO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done   (insn_done),
    .irq_req     (irq_req),
    .ret_plain   (ret_plain),
    .ret_irq     (ret_irq),
    .gie_set     (gie_set),
    .entry_busy  (entry_busy),
    .pc_load     (pc_load),
    .pc_target   (pc_target),
    .reg_restore (reg_restore),
    .gie         (gie),
    .stk_ovf     (stk_ovf),
    .stk_unf     (stk_unf)
);

// File: tb/tb_irq_ctx_seq.sv
`timescale 1ns/1ps
module tb_irq_ctx_seq;
    localparam int  PCW   = 16;
    localparam int  RW    = 8;
    localparam int  DEPTH = 4;
    localparam real HALF  = 2.5;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           insn_done, irq_req, irq_hi, ret_plain, ret_irq, gie_set;
    logic [PCW-1:0] pc_next;
    logic [RW-1:0]  w_in, status_in, bsr_in;
    logic           entry_busy, pc_load, reg_restore, gie, stk_ovf, stk_unf;
    logic [PCW-1:0] pc_target;
    logic [RW-1:0]  w_out, status_out, bsr_out;

    int n_chk = 0;
    int n_err = 0;

    always #(HALF) clk = ~clk;

    irq_ctx_seq #(.PCW(PCW), .RW(RW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
        .irq_hi(irq_hi), .ret_plain(ret_plain), .ret_irq(ret_irq),
        .gie_set(gie_set), .pc_next(pc_next), .w_in(w_in),
        .status_in(status_in), .bsr_in(bsr_in), .entry_busy(entry_busy),
        .pc_load(pc_load), .pc_target(pc_target), .reg_restore(reg_restore),
        .w_out(w_out), .status_out(status_out), .bsr_out(bsr_out),
        .gie(gie), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_gie();
        gie_set = 1'b1;
        tick();
        gie_set = 1'b0;
        chk("R12", "gie after set", gie, 1);
    endtask

    function automatic logic [RW-1:0] wv(input int i);  return RW'(i + 1);     endfunction
    function automatic logic [RW-1:0] sv(input int i);  return RW'(i * 3 + 2); endfunction
    function automatic logic [RW-1:0] bv(input int i);  return RW'(i + 7);     endfunction
    function automatic logic [PCW-1:0] pv(input int i); return PCW'(16'h0100 + i * 16'h0011); endfunction

    task automatic enter(input logic hi, input logic [PCW-1:0] pc,
                         input logic [RW-1:0] w, input logic [RW-1:0] s,
                         input logic [RW-1:0] b);
        insn_done = 1'b1; irq_req = 1'b1; irq_hi = hi;
        pc_next = pc; w_in = w; status_in = s; bsr_in = b;
        tick();
        insn_done = 1'b0; irq_req = 1'b0;
        chk("R1", "busy after entry edge", entry_busy, 1);
        chk("R4", "gie cleared on entry", gie, 0);
        chk("R3", "no load in first cycle", pc_load, 0);
        chk("R5", "shadow w", w_out, w);
        chk("R5", "shadow status", status_out, s);
        chk("R5", "shadow bsr", bsr_out, b);
        tick();
        chk("R3", "busy second cycle", entry_busy, 1);
        chk("R3", "load in second cycle", pc_load, 1);
        chk("R3", "vector", pc_target, hi ? 32'h0008 : 32'h0018);
        tick();
        chk("R3", "busy ends", entry_busy, 0);
        chk("R3", "load ends", pc_load, 0);
    endtask

    task automatic do_ret(input logic is_irq, input logic both,
                          input logic [PCW-1:0] exp_pc, input logic [RW-1:0] w,
                          input logic [RW-1:0] s, input logic [RW-1:0] b,
                          input logic exp_gie);
        ret_irq   = is_irq;
        ret_plain = !is_irq || both;
        tick();
        ret_irq = 1'b0; ret_plain = 1'b0;
        chk("R2", "return load", pc_load, 1);
        chk("R2", "popped address", pc_target, exp_pc);
        if (is_irq) begin
            chk(both ? "R11" : "R6", "restore pulse", reg_restore, 1);
            chk("R6", "gie set by reti", gie, 1);
            chk("R6", "restored w", w_out, w);
            chk("R6", "restored status", status_out, s);
            chk("R6", "restored bsr", bsr_out, b);
        end else begin
            chk("R7", "no restore on plain", reg_restore, 0);
            chk("R7", "gie unchanged", gie, exp_gie);
        end
        chk("R11", "no entry on return", entry_busy, 0);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; insn_done = 1'b0; irq_req = 1'b0; irq_hi = 1'b0;
        ret_plain = 1'b0; ret_irq = 1'b0; gie_set = 1'b0;
        pc_next = '0; w_in = '0; status_in = '0; bsr_in = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10 reset state
        chk("R10", "pc_target", pc_target, 0);
        chk("R10", "pc_load", pc_load, 0);
        chk("R10", "busy", entry_busy, 0);
        chk("R10", "gie", gie, 0);
        chk("R10", "restore", reg_restore, 0);
        chk("R10", "ovf", stk_ovf, 0);
        chk("R10", "unf", stk_unf, 0);

        // R4: request ignored while disabled
        insn_done = 1'b1; irq_req = 1'b1;
        tick();
        insn_done = 1'b0; irq_req = 1'b0;
        chk("R4", "no entry with gie low", entry_busy, 0);

        set_gie();

        // R1: request without boundary
        irq_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R1", "no entry without boundary", entry_busy, 0);
        end
        irq_req = 1'b0;

        enter(1'b1, 16'h1234, 8'h11, 8'h22, 8'h33);
        insn_done = 1'b1; irq_req = 1'b1;
        tick();
        insn_done = 1'b0; irq_req = 1'b0;
        chk("R4", "nested request ignored", entry_busy, 0);
        do_ret(1'b1, 1'b0, 16'h1234, 8'h11, 8'h22, 8'h33, 1'b1);

        // R7 plain return inside handler
        enter(1'b0, 16'h0400, 8'h44, 8'h55, 8'h66);
        set_gie();
        do_ret(1'b0, 1'b0, 16'h0400, 0, 0, 0, 1'b1);

        // R11 return beats entry at same edge
        enter(1'b1, 16'h0AAA, 8'h01, 8'h02, 8'h03);
        set_gie();
        insn_done = 1'b1; irq_req = 1'b1;
        do_ret(1'b0, 1'b0, 16'h0AAA, 0, 0, 0, 1'b1);
        insn_done = 1'b0; irq_req = 1'b0;
        tick();
        chk("R11", "still idle after precedence", entry_busy, 0);

        // R8 sweep every fill level
        for (int i = 0; i <= DEPTH; i++) begin
            enter(logic'(i[0]), pv(i), wv(i), sv(i), bv(i));
            chk("R8", "ovf at fill level", stk_ovf, (i >= DEPTH) ? 1 : 0);
            set_gie();
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            do_ret(1'b1, i == 0, pv(i), wv(DEPTH), sv(DEPTH), bv(DEPTH), 1'b1);
            chk("R8", "ovf sticky", stk_ovf, 1);
        end
        chk("R9", "no unf yet", stk_unf, 0);

        // R9 pop from empty
        do_ret(1'b0, 1'b0, 16'h0000, 0, 0, 0, 1'b1);
        chk("R9", "unf set", stk_unf, 1);
        repeat (3) tick();
        chk("R9", "unf sticky", stk_unf, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule